// File: doc/BRIEF.md
# Two-Byte Host Access UART FIFO Pair

This block holds the transmit and receive byte queues of a serial port, each 16 bytes deep by default. The host reaches both queues through one 16-bit data port. Each access moves one byte or two, as the `host_two` input selects. In a two-byte access the older byte travels in bits [7:0] and the younger byte in bits [15:8]. Single-byte strobes stand in for the serial side. `ser_tx_pop` takes the oldest transmit byte, which is always shown on `ser_tx_byte`. `ser_rx_push` stores `ser_rx_byte` in the receive queue.

The block drives one DMA request line for each direction. With `dma_mode` high, the receive request rises when the receive occupancy reaches a programmable trigger level or when a receive timeout has fired. The request line carries no indication of which of the two caused it. With `dma_mode` high, a two-byte host access that finds only one byte of room or data also sets a sticky error flag: transmit overrun or receive underrun. A short two-byte write keeps the first byte and drops the second. A short two-byte read returns the single byte in the low half and zero in the high half.

The timeout is tracked by a three-state machine. It starts in `TMO_IDLE` (queue empty). The transition IDLE→COUNT is taken when the queue holds data or on any push or pop. In `TMO_COUNT` it counts clock ticks and character times. The transition COUNT→FIRED is taken after four character times with no push or pop. The transition COUNT→IDLE is taken when the queue is empty. The state `TMO_FIRED` is left on any push or pop (FIRED→COUNT). The timeout interrupt is enabled by an active-low input.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset, both levels are 0, both error flags are 0, `tx_dma_req` is 1, `rx_dma_req` is 0 and `tmo_irq` is 0.
- R2: A host write stores one byte (`host_wdata[7:0]`) or, with `host_two`=1, two bytes, with [7:0] first and [15:8] second. `ser_tx_byte` shows the oldest byte and `tx_level` counts the stored bytes.
- R3: A two-byte write with exactly one free entry stores [7:0] and drops [15:8]. With `dma_mode`=1, any dropped write byte sets `tx_ovr_err`. With `dma_mode`=0, no flag is set.
- R4: A write to a full transmit queue stores nothing, and the level stays at the depth.
- R5: A host read returns the oldest byte in `host_rdata[7:0]`. With `host_two`=1 the next byte is in [15:8]; with `host_two`=0, [15:8] reads 0. The level drops by the number of bytes read.
- R6: A two-byte read with one stored byte returns that byte in [7:0] and 0 in [15:8], and leaves the queue empty. With `dma_mode`=1 it sets `rx_udr_err`; with `dma_mode`=0 it does not.
- R7: Both error flags stay set until a cycle with `err_clr`=1 clears them.
- R8: With `dma_mode`=1, the trigger code `rx_trig_sel` selects the trigger level: 00→1, 01→4, 10→8, 11→14. `rx_dma_req` is high when `rx_level` is at or above the trigger level.
- R9: With `dma_mode`=0, `rx_dma_req` is high exactly when the receive queue is non-empty.
- R10: `tx_dma_req` is high exactly when `tx_level` is below the depth, in both modes.
- R11: A non-empty receive queue with no push or pop for 4×`char_ticks` clock edges fires the timeout, which raises `rx_dma_req` (with `dma_mode`=1) even below the trigger level. Any push or pop restarts the count.
- R12: `tmo_irq` is high while the timeout has fired and `tmo_irq_off`=0. With `tmo_irq_off`=1 it is low.
- R13: A serial push to a full receive queue is dropped, and a serial pop of an empty transmit queue changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Host write strobe to the transmit queue |
| host_rd | input | 1 | Host read strobe from the receive queue |
| host_two | input | 1 | 1 = two-byte access, 0 = one byte |
| host_wdata | input | 16 | Write data, older byte in [7:0] |
| host_rdata | output | 16 | Read data, older byte in [7:0] |
| dma_mode | input | 1 | 0 = single-byte request mode, 1 = trigger/timeout mode with error checks |
| rx_trig_sel | input | 2 | Receive trigger code |
| tmo_irq_off | input | 1 | 0 enables the timeout interrupt |
| char_ticks | input | TW | Clock edges per character time |
| err_clr | input | 1 | Clears both error flags |
| ser_tx_pop | input | 1 | Serial side takes one transmit byte |
| ser_tx_byte | output | 8 | Oldest transmit byte |
| ser_rx_push | input | 1 | Serial side stores one receive byte |
| ser_rx_byte | input | 8 | Byte to store |
| tx_level | output | LW | Transmit occupancy |
| rx_level | output | LW | Receive occupancy |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tmo_irq | output | 1 | Timeout interrupt |
| tx_ovr_err | output | 1 | Sticky transmit overrun |
| rx_udr_err | output | 1 | Sticky receive underrun |

## Verification
A pointer or level fault shows up at the ports as a wrong `tx_level` or `rx_level`, or as a byte out of order, one edge after the access that caused it. The bench compares every pushed byte against its own queue model as the byte drains. A wrong occupancy count makes the DMA request lines disagree with the trigger arithmetic on the very next check. A wrong timeout state shows one edge early or late against the exact 4×`char_ticks` boundary that the bench samples on both sides.

// File: rtl/ufp_pkg.sv
`timescale 1ns/1ps
package ufp_pkg;

    typedef enum logic [1:0] {
        TMO_IDLE  = 2'd0,
        TMO_COUNT = 2'd1,
        TMO_FIRED = 2'd2
    } tmo_state_e;

    // Receive trigger code to occupancy threshold.
    function automatic int unsigned trig_level(input logic [1:0] code);
        unique case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/ufp_byte_fifo.sv
`timescale 1ns/1ps
module ufp_byte_fifo #(
    parameter int unsigned DEPTH     = 16,
    parameter bit          HOST_PUSH = 1'b1,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned LW    = AW + 1,
    localparam int unsigned IN_W  = HOST_PUSH ? 16 : 8,
    localparam int unsigned OUT_W = HOST_PUSH ? 8 : 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       push_cnt,
    input  logic [IN_W-1:0]  push_data,
    input  logic [1:0]       pop_cnt,
    output logic [LW-1:0]    level,
    output logic [OUT_W-1:0] head,
    output logic             host_short
);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] level_q, free;
    logic [1:0]    push_take, pop_take;
    logic [7:0]    hi_byte, lo_head;

    function automatic logic [1:0] grant(input logic [1:0] want, input logic [LW-1:0] room);
        if (room == '0) return 2'd0;
        if (want == 2'd2 && room == LW'(1)) return 2'd1;
        return want;
    endfunction

    always_comb begin
        free      = LW'(DEPTH) - level_q;
        push_take = grant(push_cnt, free);
        pop_take  = grant(pop_cnt, level_q);
        lo_head   = (level_q != '0) ? mem[rd_ptr] : 8'h00;
    end

    generate
        if (HOST_PUSH) begin : g_host_push
            assign hi_byte    = push_data[IN_W-1 -: 8];
            assign head       = lo_head;
            assign host_short = (push_take != push_cnt);

            // R3: a short write with no pop leaves the queue full
            p_short_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (host_short && pop_cnt == 2'd0) |=> (level == LW'(DEPTH)));
        end else begin : g_host_pop
            assign hi_byte    = 8'h00;
            assign head       = {(level_q >= LW'(2)) ? mem[rd_ptr + AW'(1)] : 8'h00, lo_head};
            assign host_short = (pop_take != pop_cnt);

            // R6: a short read with no push leaves the queue empty
            p_short_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (host_short && push_cnt == 2'd0) |=> (level == '0));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push_take != 2'd0) mem[wr_ptr] <= push_data[7:0];
        if (push_take == 2'd2) mem[wr_ptr + AW'(1)] <= hi_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level_q <= '0;
        end else begin
            wr_ptr  <= wr_ptr + AW'(push_take);
            rd_ptr  <= rd_ptr + AW'(pop_take);
            level_q <= level_q + LW'(push_take) - LW'(pop_take);
        end
    end

    assign level = level_q;

    // R4: occupancy never exceeds the depth
    p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

endmodule

// File: rtl/ufp_rx_timeout.sv
`timescale 1ns/1ps
module ufp_rx_timeout
    import ufp_pkg::*;
#(
    parameter int unsigned TW    = 16,
    parameter int unsigned CHARS = 4,
    localparam int unsigned CW = (CHARS > 1) ? $clog2(CHARS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] char_ticks,
    input  logic          activity,
    input  logic          nonempty,
    output logic          fired
);

    tmo_state_e    state_q, state_d;
    logic [TW-1:0] tick_q, tick_d;
    logic [CW-1:0] chr_q, chr_d;
    logic          char_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMO_IDLE;
            tick_q  <= '0;
            chr_q   <= '0;
        end else begin
            state_q <= state_d;
            tick_q  <= tick_d;
            chr_q   <= chr_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        tick_d    = tick_q;
        chr_d     = chr_q;
        char_done = ({1'b0, tick_q} + (TW+1)'(1)) >= {1'b0, char_ticks};
        unique case (state_q)
            TMO_IDLE: begin
                if (nonempty) begin
                    state_d = TMO_COUNT;
                    tick_d  = '0;
                    chr_d   = '0;
                end
            end
            TMO_COUNT: begin
                if (!nonempty) begin
                    state_d = TMO_IDLE;
                end else if (char_done) begin
                    tick_d = '0;
                    if (chr_q == CW'(CHARS - 1)) state_d = TMO_FIRED;
                    else chr_d = chr_q + CW'(1);
                end else begin
                    tick_d = tick_q + TW'(1);
                end
            end
            TMO_FIRED: begin
                if (!nonempty) state_d = TMO_IDLE;
            end
            default: state_d = TMO_IDLE;
        endcase
        if (activity) begin
            state_d = TMO_COUNT;
            tick_d  = '0;
            chr_d   = '0;
        end
    end

    always_comb begin
        fired = (state_q == TMO_FIRED);
    end

    // R11: any push or pop clears a fired timeout on the next edge
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> !fired);

    // R11: a fired timeout always has data behind it
    p_fired_has_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fired |-> nonempty);

endmodule

// File: rtl/uart_fifo_pair.sv
`timescale 1ns/1ps
module uart_fifo_pair
    import ufp_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned TW    = 16,
    parameter int unsigned CHARS = 4,
    localparam int unsigned LW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic          host_two,
    input  logic [15:0]   host_wdata,
    output logic [15:0]   host_rdata,
    input  logic          dma_mode,
    input  logic [1:0]    rx_trig_sel,
    input  logic          tmo_irq_off,
    input  logic [TW-1:0] char_ticks,
    input  logic          err_clr,
    input  logic          ser_tx_pop,
    output logic [7:0]    ser_tx_byte,
    input  logic          ser_rx_push,
    input  logic [7:0]    ser_rx_byte,
    output logic [LW-1:0] tx_level,
    output logic [LW-1:0] rx_level,
    output logic          tx_dma_req,
    output logic          rx_dma_req,
    output logic          tmo_irq,
    output logic          tx_ovr_err,
    output logic          rx_udr_err
);

    logic [1:0]    host_cnt, tx_push_cnt, tx_pop_cnt, rx_push_cnt, rx_pop_cnt;
    logic [15:0]   rx_head;
    logic          tx_short, rx_short, fired;
    logic [LW-1:0] trig_lvl;

    always_comb begin
        host_cnt    = host_two ? 2'd2 : 2'd1;
        tx_push_cnt = host_wr ? host_cnt : 2'd0;
        tx_pop_cnt  = {1'b0, ser_tx_pop};
        rx_push_cnt = {1'b0, ser_rx_push};
        rx_pop_cnt  = host_rd ? host_cnt : 2'd0;
        trig_lvl    = LW'(trig_level(rx_trig_sel));
    end

    ufp_byte_fifo #(.DEPTH(DEPTH), .HOST_PUSH(1'b1)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_cnt  (tx_push_cnt),
        .push_data (host_wdata),
        .pop_cnt   (tx_pop_cnt),
        .level     (tx_level),
        .head      (ser_tx_byte),
        .host_short(tx_short)
    );

    ufp_byte_fifo #(.DEPTH(DEPTH), .HOST_PUSH(1'b0)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_cnt  (rx_push_cnt),
        .push_data (ser_rx_byte),
        .pop_cnt   (rx_pop_cnt),
        .level     (rx_level),
        .head      (rx_head),
        .host_short(rx_short)
    );

    ufp_rx_timeout #(.TW(TW), .CHARS(CHARS)) u_rx_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_ticks(char_ticks),
        .activity  (ser_rx_push | host_rd),
        .nonempty  (rx_level != '0),
        .fired     (fired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_ovr_err <= 1'b0;
            rx_udr_err <= 1'b0;
        end else begin
            if (err_clr) begin
                tx_ovr_err <= 1'b0;
                rx_udr_err <= 1'b0;
            end
            if (dma_mode && tx_short) tx_ovr_err <= 1'b1;
            if (dma_mode && rx_short) rx_udr_err <= 1'b1;
        end
    end

    always_comb begin
        host_rdata = host_two ? rx_head : {8'h00, rx_head[7:0]};
        tx_dma_req = (tx_level < LW'(DEPTH));
        rx_dma_req = dma_mode ? ((rx_level >= trig_lvl) || fired) : (rx_level != '0);
        tmo_irq    = fired && !tmo_irq_off;
    end

    // R3: overrun only rises after a host write in the error-checking mode
    p_ovr_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ovr_err) |-> $past(host_wr && dma_mode));

    // R6: underrun only rises after a host read in the error-checking mode
    p_udr_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_udr_err) |-> $past(host_rd && dma_mode));

    // R7: flags are sticky without a clear
    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovr_err && !err_clr) |=> tx_ovr_err);
    p_udr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_udr_err && !err_clr) |=> rx_udr_err);

    // R8: the highest trigger level always requests
    p_trig_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode && rx_level >= LW'(14)) |-> rx_dma_req);

    // R12: the interrupt implies stored receive data
    p_irq_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_irq |-> (rx_level != '0));

endmodule

// File: tb/uart_fifo_pair_bench.sv
`timescale 1ns/1ps
module uart_fifo_pair_bench;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 0, host_rd = 0, host_two = 0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        dma_mode = 0;
    logic [1:0]  rx_trig_sel = 0;
    logic        tmo_irq_off = 0;
    logic [15:0] char_ticks = 16'd1000;
    logic        err_clr = 0;
    logic        ser_tx_pop = 0;
    logic [7:0]  ser_tx_byte;
    logic        ser_rx_push = 0;
    logic [7:0]  ser_rx_byte = '0;
    logic [4:0]  tx_level, rx_level;
    logic        tx_dma_req, rx_dma_req, tmo_irq, tx_ovr_err, rx_udr_err;

    int total = 0;
    int fails = 0;
    bit done = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #2 clk = ~clk;

    uart_fifo_pair u_uart_fifo_pair (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_two(host_two), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dma_mode(dma_mode), .rx_trig_sel(rx_trig_sel), .tmo_irq_off(tmo_irq_off),
        .char_ticks(char_ticks), .err_clr(err_clr), .ser_tx_pop(ser_tx_pop),
        .ser_tx_byte(ser_tx_byte), .ser_rx_push(ser_rx_push), .ser_rx_byte(ser_rx_byte),
        .tx_level(tx_level), .rx_level(rx_level), .tx_dma_req(tx_dma_req),
        .rx_dma_req(rx_dma_req), .tmo_irq(tmo_irq), .tx_ovr_err(tx_ovr_err),
        .rx_udr_err(rx_udr_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic hwrite(input bit two, input logic [15:0] d);
        host_wr = 1; host_two = two; host_wdata = d;
        step();
        host_wr = 0; host_two = 0;
    endtask

    task automatic hread(input bit two, output logic [15:0] d);
        host_rd = 1; host_two = two;
        #1 d = host_rdata;
        step();
        host_rd = 0; host_two = 0;
    endtask

    task automatic spush(input logic [7:0] b);
        ser_rx_push = 1; ser_rx_byte = b;
        step();
        ser_rx_push = 0;
    endtask

    task automatic spop();
        ser_tx_pop = 1;
        step();
        ser_tx_pop = 0;
    endtask

    task automatic clear_err();
        err_clr = 1;
        step();
        err_clr = 0;
    endtask

    task automatic drain_tx(input string tag);
        while (txq.size() != 0) begin
            chk(tag, ser_tx_byte, txq.pop_front());
            spop();
        end
        chk(tag, tx_level, 0);
    endtask

    initial begin
        logic [15:0] rd;
        int trig;

        repeat (3) step();
        // R1 reset state
        chk("R1 tx_level", tx_level, 0);
        chk("R1 rx_level", rx_level, 0);
        chk("R1 tx_ovr_err", tx_ovr_err, 0);
        chk("R1 rx_udr_err", rx_udr_err, 0);
        chk("R1 tx_dma_req", tx_dma_req, 1);
        chk("R1 rx_dma_req", rx_dma_req, 0);
        chk("R1 tmo_irq", tmo_irq, 0);
        rst_n = 1;
        step();

        // R2, R10: mixed one/two-byte fill, then drain in order
        dma_mode = 1;
        for (int k = 0; txq.size() < DEPTH; k++) begin
            bit two;
            logic [15:0] d;
            two = (k % 2 == 1) && (txq.size() <= DEPTH - 2);
            d = {8'(k * 16 + 9), 8'(k * 16 + 3)};
            hwrite(two, d);
            txq.push_back(d[7:0]);
            if (two) txq.push_back(d[15:8]);
            chk("R2 tx_level", tx_level, txq.size());
            chk("R10 tx_dma_req", tx_dma_req, (txq.size() < DEPTH) ? 1 : 0);
        end
        // R4: write at full in mode 0 is dropped, no flag
        dma_mode = 0;
        hwrite(1, 16'hEEDD);
        chk("R4 full level", tx_level, DEPTH);
        chk("R4 no flag mode0", tx_ovr_err, 0);
        drain_tx("R2 order");
        // R13: serial pop of empty transmit queue
        spop();
        chk("R13 tx empty pop", tx_level, 0);
        chk("R10 tx_dma_req empty", tx_dma_req, 1);

        // R3, R7: short two-byte write, both modes
        for (int m = 1; m >= 0; m--) begin
            dma_mode = m[0];
            for (int i = 0; i < DEPTH - 1; i++) begin
                hwrite(0, {8'h00, 8'(8'hA0 + i)});
                txq.push_back(8'(8'hA0 + i));
            end
            hwrite(1, 16'h5AC3);
            txq.push_back(8'hC3);
            chk("R3 level after short", tx_level, DEPTH);
            chk("R3 overrun flag", tx_ovr_err, m);
            repeat (3) step();
            chk("R7 overrun sticky", tx_ovr_err, m);
            drain_tx("R3 kept first byte");
            clear_err();
            chk("R7 overrun cleared", tx_ovr_err, 0);
        end

        // R8, R5, R13: trigger sweep, overfill, drain
        dma_mode = 1;
        for (int sel = 0; sel < 4; sel++) begin
            rx_trig_sel = 2'(sel);
            trig = (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
            for (int j = 0; j < DEPTH; j++) begin
                spush(8'(sel * 32 + j + 1));
                rxq.push_back(8'(sel * 32 + j + 1));
                chk("R8 rx_level", rx_level, j + 1);
                chk("R8 rx_dma_req", rx_dma_req, (j + 1 >= trig) ? 1 : 0);
            end
            spush(8'hFF);
            chk("R13 rx full push", rx_level, DEPTH);
            while (rxq.size() != 0) begin
                if (sel % 2 == 0) begin
                    hread(1, rd);
                    chk("R5 two-byte read", rd, {rxq[1], rxq[0]});
                    void'(rxq.pop_front());
                    void'(rxq.pop_front());
                end else begin
                    hread(0, rd);
                    chk("R5 one-byte read", rd, {8'h00, rxq.pop_front()});
                end
                chk("R5 rx_level", rx_level, rxq.size());
            end
            chk("R8 rx_dma_req empty", rx_dma_req, 0);
        end

        // R9: mode 0 request follows non-empty
        dma_mode = 0;
        rx_trig_sel = 2'd3;
        spush(8'h77);
        chk("R9 rx_dma_req one byte", rx_dma_req, 1);
        hread(0, rd);
        chk("R9 rx_dma_req empty", rx_dma_req, 0);

        // R6, R7: short two-byte read, both modes
        for (int m = 1; m >= 0; m--) begin
            dma_mode = m[0];
            spush(8'(8'h3C + m));
            hread(1, rd);
            chk("R6 short read data", rd, {8'h00, 8'(8'h3C + m)});
            chk("R6 empty after", rx_level, 0);
            chk("R6 underrun flag", rx_udr_err, m);
            clear_err();
            chk("R7 underrun cleared", rx_udr_err, 0);
        end

        // R11, R12: timeout edge timing
        dma_mode = 1;
        rx_trig_sel = 2'd3;
        char_ticks = 16'd3;
        tmo_irq_off = 0;
        for (int pass = 0; pass < 2; pass++) begin
            spush(8'(8'h11 + pass));
            chk("R11 restart clears", tmo_irq, 0);
            repeat (11) step();
            chk("R11 not yet fired", tmo_irq, 0);
            chk("R11 no request yet", rx_dma_req, 0);
            step();
            chk("R12 irq fired", tmo_irq, 1);
            chk("R11 request on timeout", rx_dma_req, 1);
            tmo_irq_off = 1;
            #1;
            chk("R12 irq masked", tmo_irq, 0);
            chk("R11 request while masked", rx_dma_req, 1);
            tmo_irq_off = 0;
            #1;
        end
        hread(1, rd);
        chk("R5 read both", rd, 16'h1211);
        repeat (20) step();
        chk("R11 empty no timeout", tmo_irq, 0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL R1 watchdog: actual=expired expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule